// File: doc/BRIEF.md
# Infrared Raw Symbol Capture

This block watches the output of a demodulated infrared receiver and turns the waveform into a list of timed symbols. A symbol begins at a falling edge of the receiver line. It is made of the time the line then stays low, followed by the time it stays high. Both times are counted in units of ten prescaler ticks. The prescaler is set so that one tick lasts one microsecond, which makes one unit 10 µs. Each finished symbol is written into a small FIFO, and software reads it out through a simple register port. If a high phase lasts too long, the stream is over: the block stores a final symbol whose high part is cut off, and it raises a timeout event.

Inside the block, symbols pass from the measuring stage to the FIFO over a valid/ready link. The receiver line cannot be stalled, so there is no back-pressure. When a symbol is offered while ready is low (the FIFO is full and no pop happens in that cycle), the symbol is dropped and the overflow event is raised. The symbols already stored stay in place so software can drain them. The block has three status flags (level reached, timeout, overflow), a mask for them, and one interrupt line. The register port is plain: at most one write or one read per cycle, and the read data is combinational on the address.

Top module: `ir_rawcap`

## Requirements
- R1: After reset, the registers read back as follows:
  - enable (0x00) reads 0.
  - config (0x04) reads 0x3E8000FC: width 0x3E80, level field 0, raw bit set, prescaler 124.
  - busy (0x1C), count (0x20) and status (0x2C) read 0.
  - irq is low.
- R2: A write of 1 to bit 0 of the enable register while the block is disabled makes busy (0x1C) read 1 for exactly the 8 cycles after the write, then 0.
- R3: Capture runs only when all three hold: the block is enabled, a write of any value to start (0x34) has been made since it was enabled, and busy is 0. Line activity outside that leaves the FIFO empty.
- R4: A symbol begins at a falling edge and closes at the next falling edge. Its word holds the low-phase units in bits 15:0 and the high-phase units in bits 31:16.
- R5: A phase that lasts N clock cycles records floor((N-1)/P) units, where P = 10·(prescaler+1). The prescaler is config bits 6:0.
- R6: Let W be config bits 31:16. In the high phase, the first unit at which low+high reaches W does four things:
  - it stores the symbol with high = W - low;
  - it sets the timeout status (bit 9);
  - it ends the stream;
  - the block then waits for a new falling edge.
- R7: The count register (0x20) returns the FIFO occupancy, from 0 to 16. Each read of data (0x24) returns the oldest symbol and removes it. A data read while the FIFO is empty returns 0 and changes nothing.
- R8: The level status (bit 8) is set while the occupancy is at least the level field (config bits 13:8) plus one.
- R9: A symbol offered while the FIFO is full and not being popped is dropped. This sets the overflow status (bit 10) and leaves the stored symbols and the count unchanged.
- R10: Writing the clear register (0x30) clears status flags:
  - bit 16 clears the level flag;
  - bit 17 clears the timeout flag;
  - bit 18 clears the overflow flag.
  A set condition in the same cycle wins over the clear.
- R11: Mask bits 0, 1 and 2 (at 0x28) suppress the level, timeout and overflow flags. The status register shows the raw flags in bits 10:8 and the unmasked flags in bits 26:24. irq is the OR of the unmasked flags.
- R12: Clearing enable empties the FIFO and stops capture. After enable is set again, a new start write is needed before capture resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver line, idles high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data address) |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, OR of unmasked status flags |

## Verification
The assertions assume the following about the inputs:
- The receiver line is a single-bit level that may change on any cycle.
- The register port issues at most one access per cycle.
- The configuration changes only while no stream is being measured, so the prescaler and width never move under a running phase.

The stimulus follows these rules. It writes the configuration only after a stream has ended in a timeout. It keeps low+high of every non-final symbol below the programmed width, so that only the last symbol of a burst ends the stream. It also lets each burst settle for a few cycles after the final edge before it reads any register.

// File: rtl/ir_rawcap_pkg.sv
package ir_rawcap_pkg;
  localparam int DUR_W = 16;

  localparam logic [5:0] A_ENABLE = 6'h00;
  localparam logic [5:0] A_CONFIG = 6'h04;
  localparam logic [5:0] A_BUSY   = 6'h1C;
  localparam logic [5:0] A_COUNT  = 6'h20;
  localparam logic [5:0] A_DATA   = 6'h24;
  localparam logic [5:0] A_MASK   = 6'h28;
  localparam logic [5:0] A_STATUS = 6'h2C;
  localparam logic [5:0] A_CLEAR  = 6'h30;
  localparam logic [5:0] A_START  = 6'h34;

  typedef enum logic [1:0] {MS_IDLE, MS_LOW, MS_HIGH} meter_st_e;

  // flag index order inside status, mask and clear fields
  localparam int F_LEVEL = 0;
  localparam int F_TMO   = 1;
  localparam int F_OVF   = 2;
  localparam int NFLAG   = 3;
endpackage

// File: rtl/ir_rawcap_meter.sv
module ir_rawcap_meter
  import ir_rawcap_pkg::*;
#(
  parameter int CW     = DUR_W,
  parameter int PW     = 7,
  parameter int DECADE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_in,
  input  logic          run,
  input  logic [PW-1:0] presc,
  input  logic [CW-1:0] maxw,
  output logic          sym_valid,
  output logic [2*CW-1:0] sym_data,
  output logic          eos_evt
);
  localparam int DW = $clog2(DECADE);

  logic s1_q, s2_q, sp_q;
  logic edge_w, fall_w, rise_w, unit_w, hit_w;
  logic [PW-1:0] pre_q;
  logic [DW-1:0] dec_q;
  logic [CW-1:0] lo_q, hi_q;
  logic [CW:0]   sum_w;
  meter_st_e     st_q;

  // two-flop synchronizer plus edge history, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      sp_q <= 1'b1;
    end else begin
      s1_q <= ir_in;
      s2_q <= s1_q;
      sp_q <= s2_q;
    end
  end

  assign edge_w = s2_q ^ sp_q;
  assign fall_w = edge_w & ~s2_q;
  assign rise_w = edge_w & s2_q;

  // tick prescaler and tick-to-unit divider, restarted at each edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (!run || edge_w) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (pre_q == presc) begin
      pre_q <= '0;
      dec_q <= (dec_q == DW'(DECADE-1)) ? '0 : dec_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign unit_w = run && !edge_w && (pre_q == presc) && (dec_q == DW'(DECADE-1));
  assign sum_w  = {1'b0, lo_q} + {1'b0, hi_q} + 1'b1;
  assign hit_w  = sum_w >= {1'b0, maxw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MS_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else if (!run) begin
      st_q <= MS_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      case (st_q)
        MS_IDLE: if (fall_w) begin
          st_q <= MS_LOW;
          lo_q <= '0;
          hi_q <= '0;
        end
        MS_LOW: begin
          if (rise_w) begin
            st_q <= MS_HIGH;
            hi_q <= '0;
          end else if (unit_w && lo_q != '1) begin
            lo_q <= lo_q + 1'b1;
          end
        end
        MS_HIGH: begin
          if (fall_w) begin
            st_q <= MS_LOW;
            lo_q <= '0;
            hi_q <= '0;
          end else if (unit_w) begin
            if (hit_w) st_q <= MS_IDLE;
            else       hi_q <= hi_q + 1'b1;
          end
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  assign eos_evt   = run && (st_q == MS_HIGH) && !fall_w && unit_w && hit_w;
  assign sym_valid = (run && (st_q == MS_HIGH) && fall_w) || eos_evt;
  assign sym_data  = eos_evt ? {hi_q + 1'b1, lo_q} : {hi_q, lo_q};

  logic [CW:0] out_sum_w;
  assign out_sum_w = {1'b0, sym_data[2*CW-1:CW]} + {1'b0, sym_data[CW-1:0]};

  // R6
  eos_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_evt && lo_q < maxw) |-> (out_sum_w == {1'b0, maxw}));

  // R3
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st_q == MS_IDLE && !sym_valid));

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q == MS_IDLE && fall_w) |=> (st_q == MS_LOW || !run));
endmodule

// File: rtl/ir_rawcap_fifo.sv
module ir_rawcap_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] occ_q;
  logic          do_pop, do_push;

  assign do_pop     = pop && (occ_q != '0);
  assign push_ready = (occ_q != NW'(DEPTH)) || do_pop;
  assign do_push    = push_valid && push_ready;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      occ_q <= occ_q + NW'(do_push) - NW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= push_data;
  end

  assign head = mem[rp_q];
  assign occ  = occ_q;

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= NW'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && occ_q == '0 && !push_valid && !flush) |=> (occ_q == '0));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && occ_q == NW'(DEPTH) && !pop && !flush) |=> (occ_q == NW'(DEPTH)));
endmodule

// File: rtl/ir_rawcap.sv
module ir_rawcap
  import ir_rawcap_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          SETTLE    = 8,
  parameter int          DECADE    = 10,
  parameter logic [15:0] DEF_WIDTH = 16'h3E80,
  parameter logic [6:0]  DEF_PRESC = 7'd124
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NW = $clog2(DEPTH+1);
  localparam int BW = $clog2(SETTLE+1);
  localparam logic [31:0] CFG_RST = {DEF_WIDTH, 2'b00, 6'd0, 1'b1, DEF_PRESC};

  logic              en_q, armed_q, run_w, busy_w;
  logic [BW-1:0]     busy_q;
  logic [31:0]       cfg_q;
  logic [NFLAG-1:0]  mask_q, st_q, set_w, clr_w, pend_w;
  logic              sym_valid, push_ready, eos_evt, pop_w;
  logic [2*DUR_W-1:0] sym_data, head;
  logic [NW-1:0]     occ;

  logic wr_en, wr_cfg, wr_mask, wr_clr, wr_start;
  assign wr_en    = bus_wr && bus_addr == A_ENABLE;
  assign wr_cfg   = bus_wr && bus_addr == A_CONFIG;
  assign wr_mask  = bus_wr && bus_addr == A_MASK;
  assign wr_clr   = bus_wr && bus_addr == A_CLEAR;
  assign wr_start = bus_wr && bus_addr == A_START;
  assign pop_w    = bus_rd && bus_addr == A_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      busy_q  <= '0;
      cfg_q   <= CFG_RST;
      mask_q  <= '0;
    end else begin
      if (wr_en) begin
        en_q <= bus_wdata[0];
        if (!bus_wdata[0]) begin
          armed_q <= 1'b0;
          busy_q  <= '0;
        end else if (!en_q) begin
          busy_q  <= BW'(SETTLE);
        end
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end
      if (wr_start && en_q) armed_q <= 1'b1;
      if (wr_cfg)  cfg_q  <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata[NFLAG-1:0];
    end
  end

  assign busy_w = busy_q != '0;
  assign run_w  = en_q && armed_q && !busy_w;

  ir_rawcap_meter #(.CW(DUR_W), .PW(7), .DECADE(DECADE)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_in     (ir_in),
    .run       (run_w),
    .presc     (cfg_q[6:0]),
    .maxw      (cfg_q[31:16]),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .eos_evt   (eos_evt)
  );

  ir_rawcap_fifo #(.DEPTH(DEPTH), .W(2*DUR_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (!en_q),
    .push_valid (sym_valid),
    .push_ready (push_ready),
    .push_data  (sym_data),
    .pop        (pop_w),
    .head       (head),
    .occ        (occ)
  );

  assign set_w[F_LEVEL] = 32'(occ) >= 32'(cfg_q[13:8]) + 32'd1;
  assign set_w[F_TMO]   = eos_evt;
  assign set_w[F_OVF]   = sym_valid && !push_ready;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign clr_w[g] = wr_clr && bus_wdata[16+g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q[g] <= 1'b0;
      else if (set_w[g]) st_q[g] <= 1'b1;
      else if (clr_w[g]) st_q[g] <= 1'b0;
    end
  end

  assign pend_w = st_q & ~mask_q;
  assign irq    = |pend_w;

  always_comb begin
    case (bus_addr)
      A_ENABLE: bus_rdata = {31'd0, en_q};
      A_CONFIG: bus_rdata = cfg_q;
      A_BUSY:   bus_rdata = {31'd0, busy_w};
      A_COUNT:  bus_rdata = 32'(occ);
      A_DATA:   bus_rdata = (occ != '0) ? head : 32'd0;
      A_MASK:   bus_rdata = 32'(mask_q);
      A_STATUS: bus_rdata = {5'd0, pend_w, 13'd0, st_q, 8'd0};
      default:  bus_rdata = 32'd0;
    endcase
  end

  // R2
  busy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> en_q);

  // R12
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (occ == '0));

  // R9
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !push_ready) |=> st_q[F_OVF]);

  // R11
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[F_OVF] && !mask_q[F_OVF]) |-> irq);
endmodule

// File: tb/ir_rawcap_bench.sv
module ir_rawcap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_w [32];
  logic [31:0] v;

  localparam int MW = 12;

  always #4 clk = ~clk;

  ir_rawcap u_ir_rawcap (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(input int lvl, input int presc);
    return {16'(MW), 2'b00, 6'(lvl), 1'b1, 7'(presc)};
  endfunction

  // n symbols, the last one closed by the width limit
  task automatic burst(input int n, input int base, input int p, input int mode);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int l, h, lu, hu;
      l  = 1 + ((i*7 + mode*3) % (4*p));
      lu = (l - 1) / p;
      drive(1'b0, l);
      if (i == n - 1) begin
        h  = (MW + 2) * p;
        hu = MW - lu;
      end else begin
        h  = 1 + ((i*5 + mode*11) % (4*p));
        hu = (h - 1) / p;
      end
      drive(1'b1, h);
      exp_w[base+i] = {16'(hu), 16'(lu)};
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input int n, input string tag);
    logic [31:0] d;
    rd(6'h20, d);
    chk({tag, " count"}, d, 32'(n));
    for (int i = 0; i < n; i++) begin
      rd(6'h24, d);
      chk({tag, " symbol"}, d, exp_w[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, v); chk("R1 enable", v, 32'h0);
    rd(6'h04, v); chk("R1 config", v, 32'h3E80_00FC);
    rd(6'h1C, v); chk("R1 busy", v, 32'h0);
    rd(6'h20, v); chk("R1 count", v, 32'h0);
    rd(6'h2C, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 busy window
    wr(6'h00, 32'h1);
    begin
      int nb = 0;
      bus_addr = 6'h1C;
      for (int i = 0; i < 12; i++) begin
        #1 if (bus_rdata != 0) nb++;
        @(negedge clk);
      end
      chk("R2 busy cycles", 32'(nb), 32'd8);
    end

    // R3 no capture before start
    wr(6'h04, cfgw(15, 0));
    burst(3, 0, 10, 0);
    rd(6'h20, v); chk("R3 count before start", v, 32'h0);
    wr(6'h34, 32'h5A);

    // R4 R5 R6 sweep over prescaler and length patterns
    for (int ps = 0; ps < 3; ps++) begin
      for (int m = 0; m < 4; m++) begin
        wr(6'h04, cfgw(15, ps));
        burst(10, 0, 10*(ps+1), m);
        drain(10, "R4 R5 R6 sweep");
      end
    end
    rd(6'h2C, v); chk("R6 timeout flag", (v >> 9) & 1, 32'h1);
    wr(6'h30, 32'h0002_0000);
    rd(6'h2C, v); chk("R10 timeout cleared", (v >> 9) & 1, 32'h0);

    // R8 level flag, R11 mask
    wr(6'h04, cfgw(3, 0));
    wr(6'h30, 32'h0007_0000);
    burst(3, 0, 10, 1);
    rd(6'h2C, v); chk("R8 below level", (v >> 8) & 1, 32'h0);
    burst(1, 3, 10, 2);
    rd(6'h2C, v); chk("R8 level reached", v, 32'h0300_0300);
    chk("R11 irq unmasked", 32'(irq), 32'h1);
    wr(6'h28, 32'h7);
    rd(6'h2C, v); chk("R11 masked status", v, 32'h0000_0300);
    chk("R11 irq masked", 32'(irq), 32'h0);
    wr(6'h28, 32'h0);
    drain(4, "R7 level drain");
    wr(6'h30, 32'h0003_0000);
    rd(6'h2C, v); chk("R10 clear level and timeout", v, 32'h0);
    chk("R10 irq low", 32'(irq), 32'h0);

    // R9 overflow keeps contents
    wr(6'h04, cfgw(15, 0));
    burst(18, 0, 10, 3);
    rd(6'h2C, v); chk("R9 overflow flag", (v >> 10) & 1, 32'h1);
    drain(16, "R9 overflow drain");
    rd(6'h24, v); chk("R7 empty read", v, 32'h0);
    rd(6'h20, v); chk("R7 empty count", v, 32'h0);
    wr(6'h30, 32'h0007_0000);
    rd(6'h2C, v); chk("R10 clear overflow", v, 32'h0);

    // R12 disable flushes and disarms
    burst(2, 0, 10, 0);
    rd(6'h20, v); chk("R12 count before disable", v, 32'd2);
    wr(6'h00, 32'h0);
    rd(6'h20, v); chk("R12 flushed", v, 32'h0);
    wr(6'h00, 32'h1);
    repeat (12) @(negedge clk);
    burst(2, 0, 10, 1);
    rd(6'h20, v); chk("R12 needs start", v, 32'h0);
    wr(6'h34, 32'h0);
    burst(2, 0, 10, 2);
    drain(2, "R12 restarted");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule